// File: doc/BRIEF.md
# DMA Control-Port Section

This block is the control half of a four-channel DMA controller. A host bus writes and reads it through a small register window. The upper half of that window, offsets 8 to 15, holds the controller-wide registers: a command byte, a software request port, a single-channel mask port, a per-channel mode port, a byte-pointer clear, a master clear, a clear-all-masks port and a load-all-masks port. The block keeps a status byte in which the low nibble records terminal count per channel and the high nibble records pending requests. It also keeps a four-bit mask register and four mode bytes.

External request lines are edge-sampled into the request nibble, so hardware and software requests share it. A registered arbiter offers service to one unmasked, requesting channel at a time. It picks the lowest-numbered candidate and keeps that choice until the channel's transfer section signals completion. The completion sets the channel's terminal-count bit. The byte-pointer flip-flop is also kept here. The channel section toggles it through a pulse input, and the control ports clear it.

Top module: `dmac_ctrl`

## Requirements
- R1: A command write (offset 8) is accepted when the data is 0 or when only bit 2 is set. Any other value leaves the command register unchanged. The command register drives `cmd_q`.
- R2: A request write (offset 9) selects a channel with data[1:0]. Data bit 2 equal to 1 sets status bit channel+4, and 0 clears it. Either way, status bit channel is cleared.
- R3: A single-mask write (offset 10) sets mask bit data[1:0] when data bit 2 is 1 and clears it when data bit 2 is 0. The other mask bits are kept.
- R4: A mode write (offset 11) stores the whole data byte as the mode of channel data[1:0]. Channel i's mode appears on `mode_all[8i+7:8i]`.
- R5: A master clear (offset 13) zeroes the byte pointer, the status byte and the command register, and sets all four mask bits. A write to offset 12 zeroes only the byte pointer. A `ptr_flip` pulse toggles the byte pointer.
- R6: A write to offset 14 clears every mask bit. A write to offset 15 loads the mask from data[3:0].
- R7: A read at offset 8 returns the full status byte. The read strobe's clock edge then clears status bits [3:0] and keeps bits [7:4].
- R8: A read at offset 15 returns {4'b0, mask}. A read at any other offset returns 0.
- R9: A rising edge on `ext_req[i]` sets status bit i+4. A falling edge clears it.
- R10: A channel is eligible when its mask bit is 0 and status bit i+4 is 1. `svc_sel` is one-hot or zero, and it never names an ineligible channel. When no channel is selected, the lowest-numbered eligible channel is selected one clock later.
- R11: A selection is held even when a lower channel becomes eligible. It drops as soon as its channel stops being eligible. A `done` pulse sets that channel's status bit i and releases the selection for one cycle.
- R12: After reset the block is in the master-clear state: mask 4'hF, status 0, command 0, byte pointer 0, all modes 0 and no selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational while rd_en is high) |
| ptr_flip | input | 1 | Byte-pointer toggle from the channel section |
| ext_req | input | 4 | External request lines, one per channel |
| done | input | 1 | Completion pulse for the selected channel |
| svc_sel | output | 4 | One-hot service select |
| cmd_q | output | 8 | Command register |
| mode_all | output | 32 | Four mode bytes, channel 0 in the low byte |
| byte_ptr | output | 1 | Byte-pointer flip-flop |

## Verification
The bench sweeps all 256 command values. A design that checked the wrong bits would accept a rejected value or refuse value 4. It also covers every combination of 16 mask patterns and 16 request patterns. A flawed priority scan, or an eligibility test that ignored the mask, would select the wrong channel or a masked one. Hold and release get their own sequence: a lower channel becomes eligible while a higher one is served. A design without hold would switch channels early, and one that ignored `done` would never set the terminal-count bit. Status reads are repeated to show that only the low nibble clears. External request edges, reads at unused offsets and the byte-pointer controls are checked one at a time.

// File: rtl/dmac_ctrl_pkg.sv
package dmac_ctrl_pkg;

  // Command bits that may be set in an accepted command byte
  localparam logic [7:0] CMD_ALLOWED = 8'h04;

  // Control offsets (upper half of the register window)
  localparam logic [3:0] OFS_CMD     = 4'd8;
  localparam logic [3:0] OFS_SWREQ   = 4'd9;
  localparam logic [3:0] OFS_SMASK   = 4'd10;
  localparam logic [3:0] OFS_MODE    = 4'd11;
  localparam logic [3:0] OFS_CLRPTR  = 4'd12;
  localparam logic [3:0] OFS_MCLR    = 4'd13;
  localparam logic [3:0] OFS_CLRMASK = 4'd14;
  localparam logic [3:0] OFS_ALLMASK = 4'd15;

  typedef struct packed {
    logic cmd;
    logic swreq;
    logic smask;
    logic mode;
    logic clr_ptr;
    logic mclr;
    logic clr_mask;
    logic all_mask;
    logic rd_stat;
    logic rd_mask;
  } ctl_stb_t;

  function automatic logic cmd_accept(input logic [7:0] d);
    return (d & ~CMD_ALLOWED) == 8'h00;
  endfunction

endpackage

// File: rtl/dmac_wr_decode.sv
module dmac_wr_decode
  import dmac_ctrl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output ctl_stb_t      stb
);
  logic [3:0] ofs;
  assign ofs = addr[3:0];

  always_comb begin
    stb          = '0;
    stb.cmd      = wr_en && ofs == OFS_CMD;
    stb.swreq    = wr_en && ofs == OFS_SWREQ;
    stb.smask    = wr_en && ofs == OFS_SMASK;
    stb.mode     = wr_en && ofs == OFS_MODE;
    stb.clr_ptr  = wr_en && ofs == OFS_CLRPTR;
    stb.mclr     = wr_en && ofs == OFS_MCLR;
    stb.clr_mask = wr_en && ofs == OFS_CLRMASK;
    stb.all_mask = wr_en && ofs == OFS_ALLMASK;
    stb.rd_stat  = rd_en && ofs == OFS_CMD;
    stb.rd_mask  = rd_en && ofs == OFS_ALLMASK;
  end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_ctrl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_stb_t         stb,
  input  logic [7:0]       wdata,
  input  logic             ptr_flip,
  input  logic [NCH-1:0]   ext_rise,
  input  logic [NCH-1:0]   ext_fall,
  input  logic [NCH-1:0]   tc_set,
  output logic [7:0]       cmd_q,
  output logic [NCH-1:0]   mask_q,
  output logic [2*NCH-1:0] stat_q,
  output logic [8*NCH-1:0] mode_q,
  output logic             ptr_q
);
  localparam int CW = $clog2(NCH);
  localparam int SW = 2 * NCH;

  logic [CW-1:0]  ch;
  logic [SW-1:0]  stat_n;
  logic [NCH-1:0] mask_n;

  assign ch = wdata[CW-1:0];

  always_comb begin
    stat_n = stat_q;
    if (stb.rd_stat) stat_n[NCH-1:0] = '0;
    if (stb.swreq) begin
      stat_n[NCH + int'(ch)] = wdata[2];
      stat_n[int'(ch)]       = 1'b0;
    end
    for (int i = 0; i < NCH; i++) begin
      if (ext_rise[i]) stat_n[NCH+i] = 1'b1;
      if (ext_fall[i]) stat_n[NCH+i] = 1'b0;
    end
    stat_n[NCH-1:0] = stat_n[NCH-1:0] | tc_set;
    if (stb.mclr) stat_n = '0;
  end

  always_comb begin
    mask_n = mask_q;
    if (stb.smask)    mask_n[int'(ch)] = wdata[2];
    if (stb.clr_mask) mask_n = '0;
    if (stb.all_mask) mask_n = wdata[NCH-1:0];
    if (stb.mclr)     mask_n = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
      ptr_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
      if (stb.mclr) cmd_q <= '0;
      else if (stb.cmd && cmd_accept(wdata)) cmd_q <= wdata;
      if (stb.mclr || stb.clr_ptr) ptr_q <= 1'b0;
      else if (ptr_flip) ptr_q <= ~ptr_q;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[8*g +: 8] <= '0;
      else if (stb.mode && ch == CW'(g)) mode_q[8*g +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/dmac_svc_arb.sv
module dmac_svc_arb #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  input  logic           done,
  output logic [NCH-1:0] sel,
  output logic [NCH-1:0] tc_set
);
  logic [NCH-1:0] grant_q, grant_n, lowest;
  logic           hold;

  assign lowest = elig & (~elig + NCH'(1));
  assign sel    = grant_q & elig;
  assign hold   = |sel;
  assign tc_set = done ? sel : '0;

  always_comb begin
    if (done)      grant_n = '0;
    else if (hold) grant_n = grant_q;
    else           grant_n = lowest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_n;
  end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_ctrl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             ptr_flip,
  input  logic [NCH-1:0]   ext_req,
  input  logic             done,
  output logic [NCH-1:0]   svc_sel,
  output logic [7:0]       cmd_q,
  output logic [8*NCH-1:0] mode_all,
  output logic             byte_ptr
);
  localparam int SW = 2 * NCH;

  ctl_stb_t       stb;
  logic [NCH-1:0] mask_q, ext_q, ext_rise, ext_fall, elig, tc_set, req_bits;
  logic [SW-1:0]  stat_q;
  logic           ext_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ext_req;
  end

  assign ext_rise  = ext_req & ~ext_q;
  assign ext_fall  = ~ext_req & ext_q;
  assign ext_quiet = (ext_req == ext_q);
  assign req_bits  = stat_q[SW-1:NCH];
  assign elig      = ~mask_q & req_bits;

  dmac_wr_decode #(.AW(AW)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .stb(stb)
  );

  dmac_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(wdata), .ptr_flip(ptr_flip),
    .ext_rise(ext_rise), .ext_fall(ext_fall), .tc_set(tc_set),
    .cmd_q(cmd_q), .mask_q(mask_q), .stat_q(stat_q), .mode_q(mode_all),
    .ptr_q(byte_ptr)
  );

  dmac_svc_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .done(done),
    .sel(svc_sel), .tc_set(tc_set)
  );

  always_comb begin
    rdata = '0;
    if (stb.rd_stat)      rdata = 8'(stat_q);
    else if (stb.rd_mask) rdata = 8'(mask_q);
  end
endmodule

// File: rtl/dmac_ctrl_chk.sv
module dmac_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic       done,
  input logic [3:0] svc_sel,
  input logic [7:0] cmd_q,
  input logic       byte_ptr,
  input logic [3:0] mask_q,
  input logic [7:0] stat_q,
  input logic       ext_quiet
);
  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd8 && (wdata & 8'hFB) != 8'h00) |=> $stable(cmd_q)); // R1
  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd13) |=> (mask_q == 4'hF && stat_q == 8'h00 && cmd_q == 8'h00 && !byte_ptr)); // R5
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd8 && !done) |=> stat_q[3:0] == 4'h0); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_sel)); // R10
  AST_SEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_sel & (mask_q | ~stat_q[7:4])) == 4'h0); // R10
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_sel != 4'h0 && !done && !wr_en && ext_quiet) |=> svc_sel == $past(svc_sel)); // R11
  AST_DONE_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && svc_sel != 4'h0 && !wr_en && !rd_en) |=> (stat_q[3:0] & $past(svc_sel)) == $past(svc_sel)); // R11
endmodule

bind dmac_ctrl dmac_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .done(done), .svc_sel(svc_sel), .cmd_q(cmd_q),
  .byte_ptr(byte_ptr), .mask_q(mask_q), .stat_q(stat_q), .ext_quiet(ext_quiet)
);

// File: tb/sim_dmac_ctrl.sv
module sim_dmac_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ptr_flip = 1'b0, done = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  ext_req = '0;
  logic [7:0]  rdata, cmd_q;
  logic [3:0]  svc_sel;
  logic [31:0] mode_all;
  logic        byte_ptr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dmac_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ptr_flip(ptr_flip), .ext_req(ext_req),
    .done(done), .svc_sel(svc_sel), .cmd_q(cmd_q), .mode_all(mode_all),
    .byte_ptr(byte_ptr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [3:0] first_of(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return 4'(1 << i);
    return 4'h0;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] m_cmd;
    logic [3:0] m_mask;
    logic [7:0] m_stat;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12 cmd", cmd_q, 8'h00);
    chk("R12 sel", svc_sel, 4'h0);
    chk("R12 ptr", byte_ptr, 1'b0);
    chk("R12 modes", mode_all, 32'h0);
    rd(4'd15, d); chk("R12 mask", d, 8'h0F);
    rd(4'd8, d);  chk("R12 status", d, 8'h00);

    // R1: command sweep
    m_cmd = 8'h00;
    for (int k = 0; k < 256; k++) begin
      v = 8'(k);
      wr(4'd8, v);
      if (v == 8'h00 || v == 8'h04) m_cmd = v;
      chk("R1 command", cmd_q, m_cmd);
    end

    // R4: mode writes
    for (int c = 0; c < 4; c++) begin
      v = 8'((c * 53 + 144) & 252) | 8'(c);
      wr(4'd11, v);
      chk("R4 mode", mode_all[8*c +: 8], v);
    end

    // R3, R6: mask ports
    m_mask = 4'hF;
    wr(4'd14, 8'h00); m_mask = 4'h0;
    rd(4'd15, d); chk("R6 clear all", d, {4'h0, m_mask});
    for (int k = 0; k < 8; k++) begin
      wr(4'd10, 8'(k));
      m_mask[k % 4] = (k >= 4);
      rd(4'd15, d); chk("R3 single mask", d, {4'h0, m_mask});
    end
    wr(4'd15, 8'hA5); m_mask = 4'h5;
    rd(4'd15, d); chk("R6 load all", d, {4'h0, m_mask});

    // R8: other offsets read zero
    for (int a = 0; a < 15; a++) begin
      if (a != 8) begin
        rd(4'(a), d); chk("R8 zero read", d, 8'h00);
      end
    end

    // R2: software request writes, mask all so nothing is selected
    wr(4'd15, 8'h0F);
    m_stat = 8'h00;
    for (int k = 0; k < 8; k++) begin
      wr(4'd9, 8'(k));
      m_stat[4 + (k % 4)] = (k >= 4);
      rd(4'd8, d); chk("R2 request write", d, m_stat);
    end

    // R10: mask x request sweep
    for (int r = 0; r < 16; r++) begin
      for (int m = 0; m < 16; m++) begin
        wr(4'd15, 8'h0F);
        for (int c = 0; c < 4; c++) wr(4'd9, {5'b0, r[c], 2'(c)});
        wr(4'd15, 8'(m));
        @(negedge clk);
        chk("R10 select", svc_sel, first_of(~4'(m) & 4'(r)));
      end
    end

    // R5: master clear and byte pointer
    wr(4'd8, 8'h04);
    @(negedge clk); ptr_flip = 1'b1; @(negedge clk); ptr_flip = 1'b0;
    chk("R5 ptr toggle", byte_ptr, 1'b1);
    wr(4'd12, 8'h00);
    chk("R5 ptr clear", byte_ptr, 1'b0);
    @(negedge clk); ptr_flip = 1'b1; @(negedge clk); ptr_flip = 1'b0;
    wr(4'd13, 8'h00);
    chk("R5 mclr ptr", byte_ptr, 1'b0);
    chk("R5 mclr cmd", cmd_q, 8'h00);
    rd(4'd15, d); chk("R5 mclr mask", d, 8'h0F);
    rd(4'd8, d);  chk("R5 mclr status", d, 8'h00);
    chk("R5 mclr sel", svc_sel, 4'h0);

    // R11: hold, done and release
    wr(4'd14, 8'h00);
    wr(4'd9, 8'h06);
    @(negedge clk);
    chk("R11 first grant", svc_sel, 4'h4);
    wr(4'd9, 8'h04);
    @(negedge clk);
    chk("R11 held over lower", svc_sel, 4'h4);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk("R11 release on done", svc_sel, 4'h0);
    rd(4'd8, d); chk("R11 tc set", d, 8'h54);
    chk("R10 next lowest", svc_sel, 4'h1);
    rd(4'd8, d); chk("R7 low nibble cleared", d, 8'h50);
    wr(4'd10, 8'h04);
    chk("R11 drop when masked", svc_sel, 4'h0);
    @(negedge clk);
    chk("R11 regrant other", svc_sel, 4'h4);

    // R9: external request edges
    wr(4'd13, 8'h00);
    @(negedge clk); ext_req = 4'b0010;
    @(negedge clk);
    rd(4'd8, d); chk("R9 rise", d, 8'h20);
    ext_req = 4'b1000;
    @(negedge clk);
    rd(4'd8, d); chk("R9 fall and rise", d, 8'h80);
    ext_req = 4'b0000;
    @(negedge clk);
    rd(4'd8, d); chk("R9 fall", d, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule